// File: doc/BRIEF.md
# RTC Once-per-Second Update Scheduler

This block decides when a real-time clock performs its once-per-second time and calendar update. A 15-stage countdown chain advances on each pulse of a 32.768 kHz timebase enable. When the chain wraps, the block issues a one-cycle update strobe to the downstream time counters. A fixed number of timebase ticks before each wrap, it raises an update-in-progress flag. Software reads this flag: while it is low, no update will land within the lead window, so the time registers can be read or written safely.

A 3-bit divider control field selects the chain's mode. Exactly one code runs the oscillator and lets time advance. Codes with the two upper bits set keep the oscillator on but pin the chain at its half-way point, so restarting with the run code places the first update half a second later. Any other code stops the oscillator. An inhibit input blocks all updates and drops the flag at once, while the chain keeps its phase. The block has no data stream, so every pin is a plain control or status level, and there is no valid/ready handshake. The power-on reset clears the block. The device reset input leaves the flag and the schedule untouched.

Top module: `rtc_update_ctrl`

## Requirements
- R1: Only `div_ctl` = 3'b010 (run) advances the chain, by one per `tick_en` cycle. `osc_run` is 1 for 3'b010, 3'b110 and 3'b111, and 0 for every other code.
- R2: With `div_ctl` = 3'b11x the chain is held at its half value (2^(CHAIN_W-1)), and no update strobe or flag is produced however many ticks arrive.
- R3: After `div_ctl` changes to 3'b010 from any other code, the first `upd_strobe` comes on the 2^(CHAIN_W-1)-th tick, which is 500 ms at the default width.
- R4: `uip` rises on the tick that brings the chain to 2^CHAIN_W − LEAD_TICKS, which is exactly LEAD_TICKS ticks before the tick that issues the strobe. No strobe is ever issued unless `uip` was 1 on the cycle before.
- R5: `upd_strobe` is high for exactly one clock cycle, once per 2^CHAIN_W ticks, on the tick that wraps the chain from all ones to zero. `uip` returns to 0 on the cycle after the strobe.
- R6: While `set_inhibit` is 1, no strobe is produced, and `uip` is 0 from the next cycle on. A `set_inhibit` that arrives on the same cycle as a wrapping tick wins, and that update is dropped.
- R7: Under `set_inhibit` the chain keeps counting, so updates resume on the unchanged 1 Hz phase. If the inhibit is released inside the lead window, the flag stays 0 and the wrap that follows issues no strobe.
- R8: Any code other than 3'b010 and 3'b11x stops the oscillator. It clears `uip`, puts the chain at its half value and produces no strobe.
- R9: `dev_rst_n` has no effect. While it is low, `uip`, the chain phase and the strobe timing all continue unchanged.
- R10: `por_n` low clears `uip`, `upd_strobe` and the chain (which is set to its half value).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| dev_rst_n | input | 1 | Device reset, active low; does not affect this block |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz timebase rate |
| div_ctl | input | 3 | Oscillator and divider control code |
| set_inhibit | input | 1 | Update inhibit; 1 blocks updates and clears the flag |
| osc_run | output | 1 | Oscillator enable decoded from `div_ctl` |
| uip | output | 1 | Update-in-progress status flag |
| upd_strobe | output | 1 | One-cycle update pulse to the time counters |

## Verification
The inhibit and the update can meet on one edge: `set_inhibit` rises on the same cycle as the tick that wraps the chain while `uip` is high. The bench lines the chain up at its last count with a run of ticks, then raises the inhibit and the tick on one clock. It expects no strobe and a low flag on the next sample. A second meeting is a release of the inhibit inside the lead window. It is judged by a zero strobe count across the following wrap.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;

  // Decoded divider operating modes.
  typedef enum logic [1:0] {
    DIV_STOP = 2'd0,   // oscillator off, chain parked
    DIV_HOLD = 2'd1,   // oscillator on, chain held in reset
    DIV_RUN  = 2'd2    // oscillator on, chain counting
  } div_mode_e;

  localparam logic [2:0] DIV_RUN_CODE = 3'b010;

  function automatic div_mode_e decode_div(input logic [2:0] code);
    if (code == DIV_RUN_CODE)    return DIV_RUN;
    else if (code[2:1] == 2'b11) return DIV_HOLD;
    else                         return DIV_STOP;
  endfunction

endpackage

// File: rtl/rtc_div_decode.sv
module rtc_div_decode
  import rtc_upd_pkg::*;
(
  input  logic [2:0] div_ctl,
  output div_mode_e  mode,
  output logic       osc_on
);

  always_comb begin
    mode   = decode_div(div_ctl);
    osc_on = (mode != DIV_STOP);
  end

endmodule

// File: rtl/rtc_countdown_chain.sv
module rtc_countdown_chain
  import rtc_upd_pkg::*;
#(
  parameter int CHAIN_W    = 15,
  parameter int LEAD_TICKS = 8
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               tick_en,
  input  div_mode_e          mode,
  output logic [CHAIN_W-1:0] chain_q,
  output logic               lead_hit,
  output logic               wrap_hit
);

  localparam int                 PERIOD  = 1 << CHAIN_W;
  localparam logic [CHAIN_W-1:0] HALF    = CHAIN_W'(PERIOD / 2);
  localparam logic [CHAIN_W-1:0] LAST    = {CHAIN_W{1'b1}};
  localparam logic [CHAIN_W-1:0] LEAD_AT = CHAIN_W'(PERIOD - LEAD_TICKS);

  logic               advance;
  logic [CHAIN_W-1:0] chain_nx;

  always_comb begin
    advance  = tick_en && (mode == DIV_RUN);
    chain_nx = chain_q + 1'b1;
    // Lead point is reached when this tick lands the chain on LEAD_AT.
    lead_hit = advance && (chain_nx == LEAD_AT);
    // Wrap from all ones back to zero marks the update instant.
    wrap_hit = advance && (chain_q == LAST);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      chain_q <= HALF;
    end else if (mode != DIV_RUN) begin
      chain_q <= HALF;
    end else if (tick_en) begin
      chain_q <= chain_nx;
    end
  end

  assert_hold_parks_half_R2: assert property (@(posedge clk) disable iff (!por_n)
    (mode == DIV_HOLD) |=> (chain_q == HALF));

  assert_stop_parks_half_R8: assert property (@(posedge clk) disable iff (!por_n)
    (mode == DIV_STOP) |=> (chain_q == HALF));

  assert_idle_chain_stable_R1: assert property (@(posedge clk) disable iff (!por_n)
    (mode == DIV_RUN && !tick_en) |=> $stable(chain_q));

endmodule

// File: rtl/rtc_uip_ctrl.sv
module rtc_uip_ctrl (
  input  logic clk,
  input  logic por_n,
  input  logic dev_rst_n,
  input  logic tick_en,
  input  logic running,
  input  logic set_inhibit,
  input  logic lead_hit,
  input  logic wrap_hit,
  output logic uip_q,
  output logic upd_strobe
);

  logic fire;

  // An update is only issued if the warning flag was already up.
  always_comb fire = wrap_hit && uip_q && !set_inhibit;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      uip_q      <= 1'b0;
      upd_strobe <= 1'b0;
    end else begin
      upd_strobe <= fire;
      if (set_inhibit || !running || upd_strobe) begin
        uip_q <= 1'b0;
      end else if (lead_hit) begin
        uip_q <= 1'b1;
      end
    end
  end

  assert_strobe_needs_flag_R4: assert property (@(posedge clk) disable iff (!por_n)
    upd_strobe |-> $past(uip_q));

  assert_flag_drops_after_strobe_R5: assert property (@(posedge clk) disable iff (!por_n)
    upd_strobe |=> !uip_q);

  assert_strobe_one_cycle_R5: assert property (@(posedge clk) disable iff (!por_n)
    upd_strobe |=> !upd_strobe);

  assert_inhibit_quiets_R6: assert property (@(posedge clk) disable iff (!por_n)
    set_inhibit |=> (!uip_q && !upd_strobe));

  assert_dev_reset_ignored_R9: assert property (@(posedge clk) disable iff (!por_n)
    (!dev_rst_n && !tick_en && !set_inhibit && running && !upd_strobe) |=> $stable(uip_q));

endmodule

// File: rtl/rtc_update_ctrl.sv
module rtc_update_ctrl
  import rtc_upd_pkg::*;
#(
  parameter int CHAIN_W    = 15,
  parameter int LEAD_TICKS = 8
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       dev_rst_n,
  input  logic       tick_en,
  input  logic [2:0] div_ctl,
  input  logic       set_inhibit,
  output logic       osc_run,
  output logic       uip,
  output logic       upd_strobe
);

  div_mode_e          mode;
  logic [CHAIN_W-1:0] chain_q;
  logic               lead_hit;
  logic               wrap_hit;
  logic               running;

  rtc_div_decode u_decode (
    .div_ctl (div_ctl),
    .mode    (mode),
    .osc_on  (osc_run)
  );

  rtc_countdown_chain #(
    .CHAIN_W    (CHAIN_W),
    .LEAD_TICKS (LEAD_TICKS)
  ) u_chain (
    .clk      (clk),
    .por_n    (por_n),
    .tick_en  (tick_en),
    .mode     (mode),
    .chain_q  (chain_q),
    .lead_hit (lead_hit),
    .wrap_hit (wrap_hit)
  );

  always_comb running = (mode == DIV_RUN);

  rtc_uip_ctrl u_uip (
    .clk         (clk),
    .por_n       (por_n),
    .dev_rst_n   (dev_rst_n),
    .tick_en     (tick_en),
    .running     (running),
    .set_inhibit (set_inhibit),
    .lead_hit    (lead_hit),
    .wrap_hit    (wrap_hit),
    .uip_q       (uip),
    .upd_strobe  (upd_strobe)
  );

  assert_stopped_no_flag_R8: assert property (@(posedge clk) disable iff (!por_n)
    !running |=> !uip);

  assert_strobe_needs_run_R1: assert property (@(posedge clk) disable iff (!por_n)
    upd_strobe |-> $past(running && tick_en));

endmodule

// File: tb/test_rtc_update_ctrl.sv
module test_rtc_update_ctrl;

  localparam int W    = 6;    // shortened chain: period 64 ticks, half 32
  localparam int LEAD = 8;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       dev_rst_n = 1'b1;
  logic       tick_en = 1'b0;
  logic [2:0] div_ctl = 3'b000;
  logic       set_inhibit = 1'b0;
  logic       osc_run, uip, upd_strobe;

  int n_tests = 0;
  int n_fail  = 0;
  int strobes;

  always #4 clk = ~clk;   // 125 MHz

  rtc_update_ctrl #(.CHAIN_W(W), .LEAD_TICKS(LEAD)) i_rtc_update_ctrl (
    .clk(clk), .por_n(por_n), .dev_rst_n(dev_rst_n), .tick_en(tick_en),
    .div_ctl(div_ctl), .set_inhibit(set_inhibit),
    .osc_run(osc_run), .uip(uip), .upd_strobe(upd_strobe)
  );

  // Row fields: {code[3], inhibit[1], ticks[8], strobes[3], uip_after[1]}
  localparam int NV = 15;
  localparam logic [15:0] VEC [NV] = '{
    {3'b010, 1'b0, 8'd23,  3'd0, 1'b0},  // R4 one tick short of lead point
    {3'b010, 1'b0, 8'd1,   3'd0, 1'b1},  // R4 flag rises at lead point
    {3'b010, 1'b0, 8'd8,   3'd1, 1'b0},  // R4 R5 strobe after LEAD ticks
    {3'b010, 1'b0, 8'd64,  3'd1, 1'b0},  // R5 one per period
    {3'b010, 1'b1, 8'd64,  3'd0, 1'b0},  // R6 inhibited period
    {3'b010, 1'b0, 8'd60,  3'd0, 1'b1},  // R7 phase kept under inhibit
    {3'b010, 1'b1, 8'd1,   3'd0, 1'b0},  // R6 inhibit drops flag
    {3'b010, 1'b0, 8'd3,   3'd0, 1'b0},  // R7 release in lead window skips
    {3'b110, 1'b0, 8'd100, 3'd0, 1'b0},  // R2 hold
    {3'b010, 1'b0, 8'd32,  3'd1, 1'b0},  // R3 first update at half period
    {3'b111, 1'b0, 8'd10,  3'd0, 1'b0},  // R2 hold
    {3'b000, 1'b0, 8'd10,  3'd0, 1'b0},  // R8 stop
    {3'b010, 1'b0, 8'd31,  3'd0, 1'b1},  // R3 R4 flag up, no strobe yet
    {3'b001, 1'b0, 8'd1,   3'd0, 1'b0},  // R8 stop clears flag
    {3'b010, 1'b0, 8'd40,  3'd1, 1'b0}   // R3 restart from stop
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One tick: enable high for one clock; outputs sampled after that edge.
  task automatic one_tick();
    @(negedge clk) tick_en = 1'b1;
    @(negedge clk) tick_en = 1'b0;
    if (upd_strobe) strobes++;
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) one_tick();
  endtask

  initial begin
    #1_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({7'd0, uip}, 8'd0, "R10 uip at reset");
    check({7'd0, upd_strobe}, 8'd0, "R10 strobe at reset");
    check({7'd0, osc_run}, 8'd0, "R1 osc off for 000");
    por_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [2:0] code;
      code        = VEC[v][15:13];
      div_ctl     = code;
      set_inhibit = VEC[v][12];
      strobes     = 0;
      run_ticks(int'(VEC[v][11:4]));
      @(negedge clk);
      if (upd_strobe) strobes++;
      check(8'(strobes), {5'd0, VEC[v][3:1]}, $sformatf("R1-row%0d strobes", v));
      check({7'd0, uip}, {7'd0, VEC[v][0]}, $sformatf("R4 row%0d uip", v));
      check({7'd0, osc_run},
            {7'd0, (code == 3'b010) || (code[2:1] == 2'b11)},
            $sformatf("R1 row%0d osc_run", v));
    end

    // R9: device reset while flag is up; flag and schedule unchanged.
    set_inhibit = 1'b0;
    div_ctl     = 3'b010;
    strobes     = 0;
    run_ticks(48);                 // chain 8 -> 56, flag rises
    check({7'd0, uip}, 8'd1, "R9 flag up before device reset");
    @(negedge clk) dev_rst_n = 1'b0;
    run_ticks(2);
    repeat (3) @(negedge clk);
    check({7'd0, uip}, 8'd1, "R9 flag kept through device reset");
    dev_rst_n = 1'b1;
    run_ticks(6);                  // reaches wrap
    check(8'(strobes), 8'd1, "R9 strobe on schedule");

    // R6: inhibit coincides with the wrapping tick.
    strobes = 0;
    @(negedge clk);
    run_ticks(63);                 // chain 63, flag up
    check({7'd0, uip}, 8'd1, "R6 flag up before collision");
    @(negedge clk) begin tick_en = 1'b1; set_inhibit = 1'b1; end
    @(negedge clk) tick_en = 1'b0;
    check({7'd0, upd_strobe}, 8'd0, "R6 collision strobe dropped");
    check({7'd0, uip}, 8'd0, "R6 collision flag cleared");
    check(8'(strobes), 8'd0, "R6 no strobe counted");

    // R10: power-on reset clears the flag.
    set_inhibit = 1'b0;
    run_ticks(56);
    check({7'd0, uip}, 8'd1, "R10 flag up before power-on reset");
    @(negedge clk) por_n = 1'b0;
    @(negedge clk);
    check({7'd0, uip}, 8'd0, "R10 flag cleared by power-on reset");
    por_n = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule